// File: doc/BRIEF.md
# Watchdog Configuration Lock Controller

This block guards the configuration of a watchdog timer: two control registers, a timeout value and a refresh-window value. After reset the configuration is open and may be committed once. From then on it is locked. Software regains write access only by writing a two-word key sequence to the counter address. This opens a short update window. Software may also seal the configuration so that it stays frozen until the next reset.

Writes are never applied to the live registers directly. They are staged in a shadow copy and committed together when the first control register is written. The commit happens only if the timeout, the second control register and, when window mode is on, the window value have been staged first. A key error, an unlock attempt on a sealed block, or an unlock attempt while a debugger is attached and debug running is disabled raises a one-cycle reset request. The bus write port is a plain strobe with no back-pressure. Every write is taken in the cycle its strobe is high, and a write the lock state forbids is dropped silently. The counter itself is outside this block. The block only decodes key words written to the counter address.

Register addresses are: 0 first control register, 1 second control register, 2 counter (key) address, 3 timeout, 4 window. First control register bits: [0] interrupt enable, [1] run in debug, [2] run in wait, [3] run in stop, [4] enable, [5] update allowed. Second control register bits: [0] window enable, [1] prescaler enable, [3:2] clock select, [4] interrupt flag.

Top module: `wdog_cfg_guard`

## Requirements
- R1: After reset the configuration is open, the first control register reads 0x30, the second reads 0, the timeout reads 0xFFFF, the window reads 0, and the reset request is low.
- R2: Once a configuration is committed, writes to addresses 0, 1, 3 and 4 leave every register value unchanged until an unlock succeeds.
- R3: A write to address 0 commits only if address 3 and address 1 are staged, and address 4 is also staged unless the staged window-enable bit [0] is 0. Committed values appear on the outputs one cycle after that write. Without a commit, a write to address 0 has no effect.
- R4: Writing 0x20C5 and then 0x28D9 to address 2 while locked unlocks the block when the second write lands no more than 16 clocks after the first. At 17 clocks the key pair is not accepted.
- R5: After an unlock, configuration writes are accepted for 128 clocks. The block then locks again, and anything staged without a commit is discarded.
- R6: Committing with update-allowed (bit 5) at 0 seals the block. A later 0x20C5 write to address 2 raises the reset request, and the registers stay frozen.
- R7: When 0x20C5 has been written while locked, the next write to address 2 inside the 16-clock limit that is not 0x28D9 raises the reset request, and the block stays locked.
- R8: A 0x20C5 write while locked, with the debugger attached and run-in-debug (bit 1) at 0, raises the reset request. With run-in-debug at 1 the unlock proceeds normally.
- R9: The interrupt flag (second register bit 4) is set by an interrupt event. A write to address 1 with bit 4 set clears it at any time, locked or not, and does not change the other locked fields.
- R10: The write gate has one bit per register (bit 0 address 0, bit 1 address 1, bit 2 address 3, bit 3 address 4). A gate bit is high only while the strobe addresses that register and the configuration is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe, taken in the same cycle |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 16 | Write data |
| dbg_attached | input | 1 | Debugger is attached |
| irq_event | input | 1 | Watchdog interrupt event, sets the flag |
| ctrl_a | output | 6 | Committed first control register |
| ctrl_b | output | 5 | Committed second control register with flag in bit 4 |
| timeout | output | 16 | Committed timeout value |
| window | output | 16 | Committed window value |
| cfg_open | output | 1 | Configuration currently writable |
| wr_gate | output | 4 | Per-register write enables |
| cfg_commit | output | 1 | A commit happens this cycle |
| unlock_rst_req | output | 1 | One-cycle reset request on a key violation |

## Verification
One table-driven write sequence takes the block through its whole life. It starts open, commits, drops locked writes, unlocks, recommits with update-allowed cleared, and then rejects a key on the sealed block. This separates the four lock states by their effect on the register outputs. Directed runs place the second key exactly 16 and 17 clocks after the first, and end the update window at 128 clocks. A stale staged timeout is left in the shadow copy so that a missing discard would show up in a later commit. Further runs commit with window mode on and the window unwritten. They send a wrong second key, attempt an unlock with a debugger attached under both values of the debug-run bit, and clear the interrupt flag while locked.

// File: rtl/wdog_cfg_pkg.sv
package wdog_cfg_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_REG = 4;

  localparam logic [ADDR_W-1:0] A_CTRL_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_B = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TOVAL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WINDOW = 3'd4;

  typedef enum logic [1:0] {
    PH_INIT   = 2'd0,
    PH_LOCKED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_SEALED = 2'd3
  } phase_e;

  function automatic logic [ADDR_W-1:0] gate_addr(input int idx);
    case (idx)
      0: gate_addr = A_CTRL_A;
      1: gate_addr = A_CTRL_B;
      2: gate_addr = A_TOVAL;
      default: gate_addr = A_WINDOW;
    endcase
  endfunction
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int DATA_W = 16,
  parameter int KEY_GAP = 16,
  parameter logic [DATA_W-1:0] KEY1 = 16'h20C5,
  parameter logic [DATA_W-1:0] KEY2 = 16'h28D9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              arm_en,
  output logic              unlock_ok,
  output logic              bad_key
);
  localparam int CW = (KEY_GAP > 1) ? $clog2(KEY_GAP) : 1;

  logic          armed;
  logic [CW-1:0] gap_cnt;

  assign unlock_ok = arm_en && armed && key_wr && (key_data == KEY2);
  assign bad_key   = arm_en && armed && key_wr && (key_data != KEY2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      gap_cnt <= '0;
    end else if (!arm_en) begin
      armed <= 1'b0;
    end else if (key_wr) begin
      if (!armed && key_data == KEY1) begin
        armed   <= 1'b1;
        gap_cnt <= '0;
      end else begin
        armed <= 1'b0;
      end
    end else if (armed) begin
      if (gap_cnt == CW'(KEY_GAP - 1)) armed <= 1'b0;
      else gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R7
  bad_key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> !armed);
endmodule

// File: rtl/wdog_upd_timer.sv
module wdog_upd_timer #(
  parameter int UPD_WIN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = (UPD_WIN > 1) ? $clog2(UPD_WIN) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(UPD_WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  // R5
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run);
endmodule

// File: rtl/wdog_cfg_stage.sv
module wdog_cfg_stage
  import wdog_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              open,
  input  logic              reload,
  input  logic              irq_event,
  output logic              commit,
  output logic [5:0]        ctrl_a,
  output logic [3:0]        ctrl_b_cfg,
  output logic              flag,
  output logic [DATA_W-1:0] timeout,
  output logic [DATA_W-1:0] window
);
  logic [3:0]        sh_b;
  logic [DATA_W-1:0] sh_to, sh_win;
  logic              st_b, st_to, st_win;
  logic              wr_a, wr_b, wr_to, wr_win;

  assign wr_a   = wr_valid && wr_addr == A_CTRL_A;
  assign wr_b   = wr_valid && wr_addr == A_CTRL_B;
  assign wr_to  = wr_valid && wr_addr == A_TOVAL;
  assign wr_win = wr_valid && wr_addr == A_WINDOW;

  assign commit = open && wr_a && st_to && st_b && (st_win || !sh_b[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a     <= 6'h30;
      ctrl_b_cfg <= '0;
      timeout    <= '1;
      window     <= '0;
      sh_b       <= '0;
      sh_to      <= '1;
      sh_win     <= '0;
      {st_b, st_to, st_win} <= '0;
    end else if (commit) begin
      ctrl_a     <= wr_data[5:0];
      ctrl_b_cfg <= sh_b;
      timeout    <= sh_to;
      window     <= sh_win;
      {st_b, st_to, st_win} <= '0;
    end else if (reload) begin
      sh_b   <= ctrl_b_cfg;
      sh_to  <= timeout;
      sh_win <= window;
      {st_b, st_to, st_win} <= '0;
    end else if (open) begin
      if (wr_b) begin
        sh_b <= wr_data[3:0];
        st_b <= 1'b1;
      end
      if (wr_to) begin
        sh_to <= wr_data;
        st_to <= 1'b1;
      end
      if (wr_win) begin
        sh_win <= wr_data;
        st_win <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (irq_event) flag <= 1'b1;
    else if (wr_b && wr_data[4]) flag <= 1'b0;
  end

  // R2
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(timeout) && $stable(ctrl_a) && $stable(window));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> flag);
endmodule

// File: rtl/wdog_cfg_guard.sv
module wdog_cfg_guard
  import wdog_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEY_GAP = 16,
  parameter int UPD_WIN = 128,
  parameter logic [DATA_W-1:0] KEY_UNLOCK1 = 16'h20C5,
  parameter logic [DATA_W-1:0] KEY_UNLOCK2 = 16'h28D9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_attached,
  input  logic              irq_event,
  output logic [5:0]        ctrl_a,
  output logic [4:0]        ctrl_b,
  output logic [DATA_W-1:0] timeout,
  output logic [DATA_W-1:0] window,
  output logic              cfg_open,
  output logic [3:0]        wr_gate,
  output logic              cfg_commit,
  output logic              unlock_rst_req
);
  phase_e     phase;
  logic       key_wr, key1_hit, unlock_ok, bad_key, expire;
  logic       dbg_violation, seal_violation;
  logic [3:0] b_cfg;
  logic       b_flag;

  assign key_wr   = wr_valid && wr_addr == A_COUNT;
  assign key1_hit = key_wr && wr_data == KEY_UNLOCK1;
  assign cfg_open = (phase == PH_INIT) || (phase == PH_OPEN);

  assign dbg_violation  = key1_hit && phase == PH_LOCKED && dbg_attached && !ctrl_a[1];
  assign seal_violation = key1_hit && phase == PH_SEALED;

  wdog_key_seq #(
    .DATA_W(DATA_W), .KEY_GAP(KEY_GAP), .KEY1(KEY_UNLOCK1), .KEY2(KEY_UNLOCK2)
  ) i_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data),
    .arm_en(phase == PH_LOCKED && !dbg_violation),
    .unlock_ok(unlock_ok), .bad_key(bad_key)
  );

  wdog_upd_timer #(.UPD_WIN(UPD_WIN)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(unlock_ok),
    .run(phase == PH_OPEN), .expire(expire)
  );

  wdog_cfg_stage #(.DATA_W(DATA_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .open(cfg_open), .reload(unlock_ok || expire),
    .irq_event(irq_event), .commit(cfg_commit), .ctrl_a(ctrl_a),
    .ctrl_b_cfg(b_cfg), .flag(b_flag), .timeout(timeout), .window(window)
  );

  assign ctrl_b = {b_flag, b_cfg};

  for (genvar g = 0; g < NUM_REG; g++) begin : g_gate
    assign wr_gate[g] = wr_valid && cfg_open && (wr_addr == gate_addr(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase          <= PH_INIT;
      unlock_rst_req <= 1'b0;
    end else begin
      unlock_rst_req <= bad_key || dbg_violation || seal_violation;
      if (cfg_commit) phase <= wr_data[5] ? PH_LOCKED : PH_SEALED;
      else if (unlock_ok) phase <= PH_OPEN;
      else if (expire) phase <= PH_LOCKED;
    end
  end

  // R6
  seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SEALED |=> phase == PH_SEALED);
  // R8
  rst_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_rst_req |-> $past(key_wr));
  // R10
  gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_gate));
endmodule

// File: tb/test_wdog_cfg_guard.sv
module test_wdog_cfg_guard;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  addr;
    logic [15:0] data;
    logic        exp_open;
    logic        exp_rst;
    logic [15:0] exp_to;
    logic [5:0]  exp_a;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t TBL [NVEC] = '{
    '{3'd3, 16'h1234, 1'b1, 1'b0, 16'hFFFF, 6'h30},
    '{3'd1, 16'h0002, 1'b1, 1'b0, 16'hFFFF, 6'h30},
    '{3'd0, 16'h0031, 1'b0, 1'b0, 16'h1234, 6'h31},
    '{3'd3, 16'h5555, 1'b0, 1'b0, 16'h1234, 6'h31},
    '{3'd0, 16'h0010, 1'b0, 1'b0, 16'h1234, 6'h31},
    '{3'd2, 16'h20C5, 1'b0, 1'b0, 16'h1234, 6'h31},
    '{3'd2, 16'h28D9, 1'b1, 1'b0, 16'h1234, 6'h31},
    '{3'd4, 16'h0100, 1'b1, 1'b0, 16'h1234, 6'h31},
    '{3'd1, 16'h0001, 1'b1, 1'b0, 16'h1234, 6'h31},
    '{3'd3, 16'h0800, 1'b1, 1'b0, 16'h1234, 6'h31},
    '{3'd0, 16'h0011, 1'b0, 1'b0, 16'h0800, 6'h11},
    '{3'd2, 16'h20C5, 1'b0, 1'b1, 16'h0800, 6'h11},
    '{3'd3, 16'h9999, 1'b0, 1'b0, 16'h0800, 6'h11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        dbg_attached = 1'b0;
  logic        irq_event = 1'b0;
  logic [5:0]  ctrl_a;
  logic [4:0]  ctrl_b;
  logic [15:0] timeout, window;
  logic        cfg_open, cfg_commit, unlock_rst_req;
  logic [3:0]  wr_gate;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_cfg_guard i_wdog_cfg_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .dbg_attached(dbg_attached), .irq_event(irq_event),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .timeout(timeout), .window(window),
    .cfg_open(cfg_open), .wr_gate(wr_gate), .cfg_commit(cfg_commit),
    .unlock_rst_req(unlock_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dbg_attached = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic base_cfg(input logic [15:0] a);
    wr(3'd3, 16'h0100);
    wr(3'd1, 16'h0000);
    wr(3'd0, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 open", cfg_open, 1);
    chk("R1 ctrl_a", ctrl_a, 6'h30);
    chk("R1 ctrl_b", ctrl_b, 0);
    chk("R1 timeout", timeout, 16'hFFFF);
    chk("R1 window", window, 0);
    chk("R1 rst_req", unlock_rst_req, 0);

    // R2 R3 R4 R6: life-cycle table
    for (int i = 0; i < NVEC; i++) begin
      wr(TBL[i].addr, TBL[i].data);
      chk($sformatf("R2/R6 row%0d open", i), cfg_open, TBL[i].exp_open);
      chk($sformatf("R6/R7 row%0d rst", i), unlock_rst_req, TBL[i].exp_rst);
      chk($sformatf("R3 row%0d timeout", i), timeout, TBL[i].exp_to);
      chk($sformatf("R2 row%0d ctrl_a", i), ctrl_a, TBL[i].exp_a);
    end
    chk("R3 window committed", window, 16'h0100);
    chk("R6 ctrl_b sealed", ctrl_b, 5'h01);

    // R3: window enabled but window not staged blocks commit
    do_reset();
    wr(3'd3, 16'h0042);
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0030);
    chk("R3 no commit open", cfg_open, 1);
    chk("R3 no commit timeout", timeout, 16'hFFFF);
    wr(3'd4, 16'h0010);
    wr(3'd0, 16'h0030);
    chk("R3 commit timeout", timeout, 16'h0042);
    chk("R3 commit window", window, 16'h0010);

    // R10 gates
    wr_valid = 1'b1; wr_addr = 3'd3; #1;
    chk("R10 gate locked", wr_gate, 4'b0000);
    wr_valid = 1'b0;

    // R4 gap of exactly 16 clocks accepted
    do_reset();
    base_cfg(16'h0030);
    wr(3'd2, 16'h20C5);
    idle(15);
    wr(3'd2, 16'h28D9);
    chk("R4 gap16 unlock", cfg_open, 1);
    wr_valid = 1'b1; wr_addr = 3'd3; #1;
    chk("R10 gate open", wr_gate, 4'b0100);
    wr_valid = 1'b0;
    @(negedge clk);

    // R4 gap of 17 clocks refused
    do_reset();
    base_cfg(16'h0030);
    wr(3'd2, 16'h20C5);
    idle(16);
    wr(3'd2, 16'h28D9);
    chk("R4 gap17 locked", cfg_open, 0);
    chk("R4 gap17 no rst", unlock_rst_req, 0);

    // R5 window of 128 clocks and discard of partial writes
    do_reset();
    base_cfg(16'h0030);
    wr(3'd2, 16'h20C5);
    wr(3'd2, 16'h28D9);
    wr(3'd3, 16'h0777);
    idle(126);
    chk("R5 still open at 127", cfg_open, 1);
    idle(1);
    chk("R5 closed at 128", cfg_open, 0);
    chk("R5 timeout kept", timeout, 16'h0100);
    wr(3'd2, 16'h20C5);
    wr(3'd2, 16'h28D9);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0030);
    chk("R5 stale stage discarded", timeout, 16'h0100);
    chk("R5 reopened", cfg_open, 1);

    // R7 wrong second key
    do_reset();
    base_cfg(16'h0030);
    wr(3'd2, 16'h20C5);
    wr(3'd2, 16'h1111);
    chk("R7 rst_req", unlock_rst_req, 1);
    chk("R7 locked", cfg_open, 0);
    @(negedge clk);
    chk("R7 pulse ends", unlock_rst_req, 0);

    // R8 debugger attached, debug run off
    do_reset();
    base_cfg(16'h0030);
    dbg_attached = 1'b1;
    wr(3'd2, 16'h20C5);
    chk("R8 dbg rst_req", unlock_rst_req, 1);
    // R8 debug run on
    do_reset();
    base_cfg(16'h0032);
    dbg_attached = 1'b1;
    wr(3'd2, 16'h20C5);
    chk("R8 dbgrun no rst", unlock_rst_req, 0);
    wr(3'd2, 16'h28D9);
    chk("R8 dbgrun unlock", cfg_open, 1);

    // R9 flag
    do_reset();
    wr(3'd3, 16'h0100);
    wr(3'd1, 16'h0006);
    wr(3'd0, 16'h0030);
    irq_event = 1'b1;
    @(negedge clk);
    irq_event = 1'b0;
    chk("R9 flag set", ctrl_b, 5'h16);
    wr(3'd1, 16'h0000);
    chk("R9 locked write keeps", ctrl_b, 5'h16);
    wr(3'd1, 16'h0010);
    chk("R9 flag cleared", ctrl_b, 5'h06);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule